// File: doc/BRIEF.md
# Training and Skip Ordered Set Generator

This block sits between a link training state machine, the data link layer and the per-lane PHY of a multi-lane serial link. Every cycle it drives one 8-bit symbol and one control flag on each lane. While the training state machine asks for training sets, the block emits 16-symbol TS1 or TS2 sets on all lanes at once. The link number and lane number fields can be replaced by the PAD control symbol. When no ordered set is in progress, the data link layer's symbols pass through unchanged.

A free-running interval timer requests a skip (SKP) ordered set. The request stays pending until the current ordered set has finished and the data link layer reports that no packet is open. Only then is the skip set sent. A small handshake also lets the training state machine ask the PHY for a receiver detection and get the answer back.

Top module: `osg_top`

## Requirements
- R1: In every cycle of a skip set, and in every TS symbol other than the lane number field, all lanes carry the same symbol and control flag. Without PAD forcing, the lane number field (symbol index 2) carries the lane's own index as data (control flag 0).
- R2: A training set is 16 symbols, in this order: 0xBC with control 1; link number; lane number; N_FTS; rate ID; training control; then ten identifier symbols. The identifier is 0x4A for TS1 (`ts_kind` = 0) and 0x45 for TS2 (`ts_kind` = 1). Symbols 1 to 15 are data (control 0). All field inputs, `ts_kind` and `pad_force` are captured in the cycle the set starts and hold for the whole set.
- R3: When the captured `pad_force` is 1, symbols 1 and 2 of the training set are 0xF7 with control 1 on every lane.
- R4: A skip set is 0xBC followed by three 0x1C symbols, all with control 1.
- R5: The interval timer counts cycles from reset release and expires every SKP_INTERVAL cycles, first in the SKP_INTERVAL-th cycle. Each expiry marks a skip set as pending. Further expiries while one is already pending do not queue a second set.
- R6: A pending skip set starts only in a cycle where no ordered set is in progress and `pkt_active` is 0. In such a cycle it takes priority over a training request.
- R7: In a cycle with no ordered set in progress and none started, each lane outputs its `dl_data` byte and `dl_k` bit.
- R8: Outputs are registered. A symbol chosen in one cycle appears on `lane_sym`/`lane_k` after the next rising edge. During reset all outputs are 0.
- R9: A `rxdet_start` pulse raises `phy_det_req` in the next cycle. It stays high until a cycle with `phy_det_done` = 1. In the cycle after that, `rxdet_done` pulses for one cycle and `rxdet_present` holds the `phy_det_result` seen with done.
- R10: `rxdet_start` has no effect while `phy_det_req` is high. `phy_det_done` has no effect while `phy_det_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ts_req | input | 1 | Request training sets |
| ts_kind | input | 1 | 0 = TS1, 1 = TS2 |
| pad_force | input | 1 | Replace link and lane fields with PAD |
| link_num | input | 8 | Link number field |
| n_fts | input | 8 | N_FTS field |
| rate_id | input | 8 | Rate identifier field |
| train_ctl | input | 8 | Training control field |
| pkt_active | input | 1 | Data link layer packet in flight |
| dl_data | input | LANES*8 | Data link symbols, lane l at bits l*8+:8 |
| dl_k | input | LANES | Data link control flags |
| lane_sym | output | LANES*8 | Symbol per lane |
| lane_k | output | LANES | Control flag per lane |
| rxdet_start | input | 1 | Start a receiver detection |
| phy_det_req | output | 1 | Detection request to the PHY |
| phy_det_done | input | 1 | PHY finished detection |
| phy_det_result | input | 1 | PHY detection result |
| rxdet_done | output | 1 | One-cycle result strobe |
| rxdet_present | output | 1 | Receiver present result |

## Verification
The timer can expire in the same cycle that a training set ends while `ts_req` is still high. The bench provokes this by holding `ts_req` for several timer periods with a short interval, so skip sets land at TS boundaries. A second case holds `pkt_active` high across expiries, both with and without training, so that a pending skip set has to wait. A behavioural reference model, built on symbol queues, predicts the symbol on every lane in every cycle. The model's order is skip before training, and neither one ever cuts a set short. In the bench, a receiver detection start is also issued while one is already busy, and a PHY done pulse is sent with no request open.

// File: rtl/osg_pkg.sv
package osg_pkg;
  localparam logic [7:0] SYM_COM    = 8'hBC;
  localparam logic [7:0] SYM_PAD    = 8'hF7;
  localparam logic [7:0] SYM_SKP    = 8'h1C;
  localparam logic [7:0] SYM_TS1_ID = 8'h4A;
  localparam logic [7:0] SYM_TS2_ID = 8'h45;
  localparam int TS_LEN  = 16;
  localparam int SKP_LEN = 4;
  localparam int IDX_W   = $clog2(TS_LEN);

  typedef enum logic [1:0] {SEL_DATA, SEL_TS, SEL_SKP} sel_e;

  typedef struct packed {
    logic [7:0] link;
    logic [7:0] nfts;
    logic [7:0] rate;
    logic [7:0] tctl;
    logic       ts2;
    logic       pad;
  } ts_fields_t;
endpackage

// File: rtl/osg_skp_timer.sv
module osg_skp_timer #(
  parameter int INTERVAL = 1180
) (
  input  logic clk,
  input  logic rst,
  input  logic take,
  output logic pending
);
  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q;
  logic          expire;

  assign expire = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      pending <= 1'b0;
    end else begin
      cnt_q   <= expire ? '0 : cnt_q + 1'b1;
      pending <= (pending & ~take) | expire;
    end
  end

  // R5: a pending request is only dropped when a skip set takes it
  assert_pending_held_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(pending) |-> $past(take));
endmodule

// File: rtl/osg_seq.sv
module osg_seq
  import osg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 skp_pending,
  input  logic                 pkt_active,
  input  logic                 ts_req,
  input  ts_fields_t           fields_in,
  output sel_e                 sel,
  output logic [IDX_W-1:0]     idx,
  output ts_fields_t           fields,
  output logic                 skp_take
);
  localparam logic [IDX_W-1:0] TS_LAST  = IDX_W'(TS_LEN - 1);
  localparam logic [IDX_W-1:0] SKP_LAST = IDX_W'(SKP_LEN - 1);

  sel_e             state_q;
  logic [IDX_W-1:0] cnt_q;
  ts_fields_t       fld_q;
  logic             last;

  always_comb begin
    sel      = state_q;
    idx      = cnt_q;
    fields   = fld_q;
    skp_take = 1'b0;
    if (state_q == SEL_DATA) begin
      idx = '0;
      if (skp_pending && !pkt_active) begin
        sel      = SEL_SKP;
        skp_take = 1'b1;
      end else if (ts_req) begin
        sel    = SEL_TS;
        fields = fields_in;
      end else begin
        sel = SEL_DATA;
      end
    end
  end

  assign last = ((sel == SEL_TS) && (idx == TS_LAST)) ||
                ((sel == SEL_SKP) && (idx == SKP_LAST));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEL_DATA;
      cnt_q   <= '0;
      fld_q   <= '0;
    end else begin
      if ((sel != SEL_DATA) && !last) begin
        state_q <= sel;
        cnt_q   <= idx + 1'b1;
      end else begin
        state_q <= SEL_DATA;
        cnt_q   <= '0;
      end
      fld_q <= fields;
    end
  end

  // R6: a skip set never begins while a packet is open
  assert_skp_outside_packet_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEL_SKP && cnt_q == 1) |-> !$past(pkt_active));

  // R2: a training set runs to its final symbol without interruption
  assert_ts_runs_full_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEL_TS && cnt_q == TS_LAST - 1'b1) |=> (state_q == SEL_TS && cnt_q == TS_LAST));

  // R2: captured fields stay constant while a set is in progress
  assert_fields_stable_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEL_TS && cnt_q > 1) |-> $stable(fld_q));
endmodule

// File: rtl/osg_lane.sv
module osg_lane
  import osg_pkg::*;
#(
  parameter int LANE_ID = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  sel_e             sel,
  input  logic [IDX_W-1:0] idx,
  input  ts_fields_t       fields,
  input  logic [7:0]       d_in,
  input  logic             k_in,
  output logic [7:0]       sym_q,
  output logic             k_q
);
  logic [7:0] sym_d;
  logic       k_d;

  always_comb begin
    sym_d = d_in;
    k_d   = k_in;
    unique case (sel)
      SEL_SKP: begin
        sym_d = (idx == 0) ? SYM_COM : SYM_SKP;
        k_d   = 1'b1;
      end
      SEL_TS: begin
        k_d = 1'b0;
        case (idx)
          4'd0: begin sym_d = SYM_COM; k_d = 1'b1; end
          4'd1: begin sym_d = fields.pad ? SYM_PAD : fields.link; k_d = fields.pad; end
          4'd2: begin sym_d = fields.pad ? SYM_PAD : 8'(LANE_ID); k_d = fields.pad; end
          4'd3: sym_d = fields.nfts;
          4'd4: sym_d = fields.rate;
          4'd5: sym_d = fields.tctl;
          default: sym_d = fields.ts2 ? SYM_TS2_ID : SYM_TS1_ID;
        endcase
      end
      default: begin
        sym_d = d_in;
        k_d   = k_in;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sym_q <= '0;
      k_q   <= 1'b0;
    end else begin
      sym_q <= sym_d;
      k_q   <= k_d;
    end
  end
endmodule

// File: rtl/osg_rxdet.sv
module osg_rxdet (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic phy_done,
  input  logic phy_result,
  output logic phy_req,
  output logic done,
  output logic present
);
  always_ff @(posedge clk) begin
    if (rst) begin
      phy_req <= 1'b0;
      done    <= 1'b0;
      present <= 1'b0;
    end else if (phy_req && phy_done) begin
      phy_req <= 1'b0;
      done    <= 1'b1;
      present <= phy_result;
    end else begin
      done <= 1'b0;
      if (start && !phy_req) phy_req <= 1'b1;
    end
  end

  // R9: the request only drops on a PHY completion
  assert_req_until_done_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(phy_req) |-> $past(phy_done));

  // R9 / R10: a result strobe needs an open request the cycle before
  assert_done_after_req_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(phy_req));
endmodule

// File: rtl/osg_top.sv
module osg_top
  import osg_pkg::*;
#(
  parameter int LANES        = 4,
  parameter int SKP_INTERVAL = 1180
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ts_req,
  input  logic               ts_kind,
  input  logic               pad_force,
  input  logic [7:0]         link_num,
  input  logic [7:0]         n_fts,
  input  logic [7:0]         rate_id,
  input  logic [7:0]         train_ctl,
  input  logic               pkt_active,
  input  logic [LANES*8-1:0] dl_data,
  input  logic [LANES-1:0]   dl_k,
  output logic [LANES*8-1:0] lane_sym,
  output logic [LANES-1:0]   lane_k,
  input  logic               rxdet_start,
  output logic               phy_det_req,
  input  logic               phy_det_done,
  input  logic               phy_det_result,
  output logic               rxdet_done,
  output logic               rxdet_present
);
  sel_e             sel;
  sel_e             sel_q;
  logic [IDX_W-1:0] idx;
  ts_fields_t       fields_in;
  ts_fields_t       fields;
  logic             skp_pending;
  logic             skp_take;

  assign fields_in = '{link: link_num, nfts: n_fts, rate: rate_id,
                       tctl: train_ctl, ts2: ts_kind, pad: pad_force};

  osg_skp_timer #(.INTERVAL(SKP_INTERVAL)) u_timer (
    .clk(clk), .rst(rst), .take(skp_take), .pending(skp_pending));

  osg_seq u_seq (
    .clk(clk), .rst(rst), .skp_pending(skp_pending), .pkt_active(pkt_active),
    .ts_req(ts_req), .fields_in(fields_in), .sel(sel), .idx(idx),
    .fields(fields), .skp_take(skp_take));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    osg_lane #(.LANE_ID(l)) u_lane (
      .clk(clk), .rst(rst), .sel(sel), .idx(idx), .fields(fields),
      .d_in(dl_data[l*8 +: 8]), .k_in(dl_k[l]),
      .sym_q(lane_sym[l*8 +: 8]), .k_q(lane_k[l]));

    if (l > 0) begin : g_chk
      // R1: skip symbols are identical on every lane
      assert_lanes_agree_R1: assert property (@(posedge clk) disable iff (rst)
        (sel_q == SEL_SKP) |-> (lane_sym[l*8 +: 8] == lane_sym[7:0] && lane_k[l] == lane_k[0]));
    end
  end

  osg_rxdet u_rxdet (
    .clk(clk), .rst(rst), .start(rxdet_start), .phy_done(phy_det_done),
    .phy_result(phy_det_result), .phy_req(phy_det_req), .done(rxdet_done),
    .present(rxdet_present));

  always_ff @(posedge clk) begin
    if (rst) sel_q <= SEL_DATA;
    else     sel_q <= sel;
  end

  // R4: the first symbol after a skip start is the comma with control set
  assert_skp_starts_com_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(sel_q) != SEL_SKP && sel_q == SEL_SKP) |-> (lane_sym[7:0] == SYM_COM && lane_k[0]));
endmodule

// File: tb/sim_osg_top.sv
module sim_osg_top;
  localparam int LANES = 4;
  localparam int INTV  = 37;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ts_req = 0, ts_kind = 0, pad_force = 0, pkt_active = 0;
  logic [7:0] link_num = 8'h05, n_fts = 8'h20, rate_id = 8'h02, train_ctl = 8'h00;
  logic [LANES*8-1:0] dl_data = '0;
  logic [LANES-1:0]   dl_k = '0;
  logic [LANES*8-1:0] lane_sym;
  logic [LANES-1:0]   lane_k;
  logic rxdet_start = 0, phy_det_done = 0, phy_det_result = 0;
  logic phy_det_req, rxdet_done, rxdet_present;

  always #10 clk = ~clk;

  osg_top #(.LANES(LANES), .SKP_INTERVAL(INTV)) u0 (
    .clk(clk), .rst(rst), .ts_req(ts_req), .ts_kind(ts_kind), .pad_force(pad_force),
    .link_num(link_num), .n_fts(n_fts), .rate_id(rate_id), .train_ctl(train_ctl),
    .pkt_active(pkt_active), .dl_data(dl_data), .dl_k(dl_k),
    .lane_sym(lane_sym), .lane_k(lane_k), .rxdet_start(rxdet_start),
    .phy_det_req(phy_det_req), .phy_det_done(phy_det_done),
    .phy_det_result(phy_det_result), .rxdet_done(rxdet_done),
    .rxdet_present(rxdet_present));

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit started = 0;
  bit finished = 0;

  // behavioural reference model
  bit [8:0]  q_sym[$];
  bit        q_lf[$];
  string     q_tag[$];
  int        tcnt;
  bit        pend, expire, took;
  bit [8:0]  s;
  bit        lf;
  logic [7:0] exp_sym[LANES];
  logic       exp_k[LANES];
  string      tag = "R8";
  bit m_req, m_done, m_pres;
  string rx_tag = "R9";

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cyc=%0d act=%h exp=%h", req, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    started = 1;
    cyc++;
    if (rst) begin
      q_sym.delete(); q_lf.delete(); q_tag.delete();
      tcnt = 0; pend = 0;
      for (int l = 0; l < LANES; l++) begin exp_sym[l] = 8'h00; exp_k[l] = 1'b0; end
      tag = "R8";
      m_req = 0; m_done = 0; m_pres = 0;
    end else begin
      expire = (tcnt == INTV - 1);
      tcnt   = expire ? 0 : tcnt + 1;
      took   = 0;
      if (q_sym.size() == 0) begin
        if (pend && !pkt_active) begin
          // R5 R6: pending skip set goes out at a boundary, ahead of training
          q_sym.push_back({1'b1, 8'hBC}); q_lf.push_back(0); q_tag.push_back("R4");
          for (int i = 0; i < 3; i++) begin
            q_sym.push_back({1'b1, 8'h1C}); q_lf.push_back(0); q_tag.push_back("R6");
          end
          took = 1;
        end else if (ts_req) begin
          q_sym.push_back({1'b1, 8'hBC}); q_lf.push_back(0); q_tag.push_back("R2");
          if (pad_force) begin
            q_sym.push_back({1'b1, 8'hF7}); q_lf.push_back(0); q_tag.push_back("R3");
            q_sym.push_back({1'b1, 8'hF7}); q_lf.push_back(0); q_tag.push_back("R3");
          end else begin
            q_sym.push_back({1'b0, link_num}); q_lf.push_back(0); q_tag.push_back("R2");
            q_sym.push_back({1'b0, 8'h00});    q_lf.push_back(1); q_tag.push_back("R1");
          end
          q_sym.push_back({1'b0, n_fts});     q_lf.push_back(0); q_tag.push_back("R2");
          q_sym.push_back({1'b0, rate_id});   q_lf.push_back(0); q_tag.push_back("R2");
          q_sym.push_back({1'b0, train_ctl}); q_lf.push_back(0); q_tag.push_back("R2");
          for (int i = 0; i < 10; i++) begin
            q_sym.push_back({1'b0, ts_kind ? 8'h45 : 8'h4A}); q_lf.push_back(0); q_tag.push_back("R2");
          end
        end
      end
      if (q_sym.size() != 0) begin
        s = q_sym.pop_front(); lf = q_lf.pop_front(); tag = q_tag.pop_front();
        for (int l = 0; l < LANES; l++) begin
          exp_sym[l] = lf ? 8'(l) : s[7:0];
          exp_k[l]   = s[8];
        end
      end else begin
        tag = "R7";
        for (int l = 0; l < LANES; l++) begin
          exp_sym[l] = dl_data[l*8 +: 8];
          exp_k[l]   = dl_k[l];
        end
      end
      pend = (pend && !took) || expire;   // R5: at most one pending
      if (m_req && phy_det_done) begin
        m_req = 0; m_done = 1; m_pres = phy_det_result;
      end else begin
        m_done = 0;
        if (rxdet_start && !m_req) m_req = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (started && !finished) begin
      for (int l = 0; l < LANES; l++) begin
        chk(tag, {23'd0, lane_k[l], lane_sym[l*8 +: 8]}, {23'd0, exp_k[l], exp_sym[l]});
      end
      chk(rst ? "R8" : rx_tag, {29'd0, phy_det_req, rxdet_done, rxdet_present},
          {29'd0, m_req, m_done, m_pres});
    end
    for (int l = 0; l < LANES; l++) dl_data[l*8 +: 8] = 8'(cyc * 7 + l * 13);
    dl_k = LANES'(cyc * 5);
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up;
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    wait_cycles(5);
    rst = 0;                                  // R8 checked while reset was high
    wait_cycles(20);                          // R7 passthrough
    pkt_active = 1; wait_cycles(60);          // R6: expiries while packet open
    pkt_active = 0; wait_cycles(10);
    ts_req = 1; ts_kind = 0; pad_force = 0;   // R2 TS1 with lane numbers (R1)
    wait_cycles(7);
    link_num = 8'h3C; n_fts = 8'h81; rate_id = 8'h06; train_ctl = 8'h01; // mid-set change
    wait_cycles(40);
    ts_kind = 1; pad_force = 1;               // R3 TS2 padded, SKP collisions (R5 R6)
    wait_cycles(90);
    pkt_active = 1; pad_force = 0; wait_cycles(50);
    pkt_active = 0; wait_cycles(30);
    ts_req = 0; wait_cycles(20);
    // R9 receiver detect
    rxdet_start = 1; wait_cycles(1); rxdet_start = 0;
    wait_cycles(3);
    phy_det_done = 1; phy_det_result = 1; wait_cycles(1);
    phy_det_done = 0; phy_det_result = 0; wait_cycles(3);
    // R10: start while busy, done with no request
    rx_tag = "R10";
    rxdet_start = 1; wait_cycles(1); rxdet_start = 0; wait_cycles(2);
    rxdet_start = 1; wait_cycles(1); rxdet_start = 0; wait_cycles(2);
    phy_det_done = 1; phy_det_result = 0; wait_cycles(1);
    phy_det_done = 0; wait_cycles(2);
    phy_det_done = 1; phy_det_result = 1; wait_cycles(1);
    phy_det_done = 0; phy_det_result = 0; wait_cycles(2);
    rxdet_start = 1; phy_det_done = 1; wait_cycles(1);
    rxdet_start = 0; phy_det_done = 0; wait_cycles(4);
    phy_det_done = 1; phy_det_result = 1; wait_cycles(1);
    phy_det_done = 0; wait_cycles(40);
    finish_up();
  end
endmodule